// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block records the time at which events happen on a single input line. A free-running time base counts system clocks through a selectable prescaler, either as a 16-bit or as a 32-bit counter. The input line passes through a two-flop synchronizer. Its edges are then qualified by a 4-bit mode code: rising edges, falling edges, both edges, or only every 4th or every 16th rising edge. On each qualifying event the current time base value is copied into a capture register, and a capture flag is raised for one clock.

Software-side control goes through one 8-bit control word, which is written through a strobe and can be read back. The time base and the most recent captured value are presented directly on output ports. Writing the control word with its enable bit clear stops the block and returns every control field to zero.

Top module: `icap_unit`

## Requirements
- R1: The control word is laid out as bit 0 enable, bits 2:1 prescale code, bit 3 width select, bits 7:4 mode code. A write with the enable bit set stores the word, and `ctl_rdata` shows it from the clock after the write.
- R2: A write with the enable bit clear stores zero in every field. While the block is disabled the time base stays at zero and no capture occurs.
- R3: The prescale code selects the time base divider: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. Let e be the clock edge of an enabling write issued while the block is disabled, and D the divider. After edge e+n, `tb_count` equals floor(n/D).
- R4: Width select 1 gives a 32-bit time base. Width select 0 gives a 16-bit time base that wraps from 0xFFFF to 0. In that case bits 31:16 of `tb_count` and of `cap_value` read as zero.
- R5: Mode 0001 captures on every rising edge only. Mode 0010 captures on every falling edge only.
- R6: Modes 0000 and 0011 capture on every rising edge and on every falling edge.
- R7: Mode 0100 captures on every 4th rising edge and mode 0101 on every 16th. The rising-edge count is cleared by disabling and by any write that changes the mode code, but not by a write that keeps it. The first capture after a clear is therefore the 4th (or 16th) rising edge after it.
- R8: Mode codes 0110, 0111 and 1xxx never capture, and `cap_value` keeps its previous contents.
- R9: Suppose the input changes between edges j-1 and j and the change qualifies. Then `cap_flag` is high for exactly the one cycle after edge j+2. `cap_value` then holds the `tb_count` value that was present just before edge j+2.
- R10: After reset, `ctl_rdata`, `tb_count`, `cap_value` and `cap_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Current control word |
| cap_in | input | 1 | Asynchronous event input |
| tb_count | output | 32 | Current time base value |
| cap_value | output | 32 | Most recently captured time base value |
| cap_flag | output | 1 | One-cycle pulse on each capture |

## Verification
The capture path is fixed at a three-edge latency. A fault in the synchronizer, the edge detector or the every-Nth counter therefore shows up as a missing, extra or shifted `cap_flag` within three clocks of the input change that exposes it. A wrong prescaler or counter state shows up as a `cap_value` that is off from floor(n/D), or as a bad `tb_count` read on the next cycle. A fault in the 16-bit wrap appears exactly at the 65536th time base step. The every-Nth counter can hold stale state after a mode change or a disable, and that stays hidden until the 4th or 16th rising edge that follows, when the capture lands on the wrong edge.

// File: rtl/icap_pkg.sv
package icap_pkg;

  localparam int CTL_W = 8;

  typedef struct packed {
    logic [3:0] mode;
    logic       wide;
    logic [1:0] psc;
    logic       en;
  } icap_ctl_t;

  localparam logic [3:0] MD_BOTH_A = 4'd0;
  localparam logic [3:0] MD_RISE   = 4'd1;
  localparam logic [3:0] MD_FALL   = 4'd2;
  localparam logic [3:0] MD_BOTH_B = 4'd3;
  localparam logic [3:0] MD_NTH_A  = 4'd4;
  localparam logic [3:0] MD_NTH_B  = 4'd5;

endpackage

// File: rtl/icap_timebase.sv
module icap_timebase #(
  parameter int TB_W     = 32,
  parameter int NARROW_W = 16,
  parameter int PS_W     = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            wide,
  input  logic [1:0]      psc,
  output logic [TB_W-1:0] count
);

  logic [PS_W-1:0] pc_q;
  logic [PS_W-1:0] lim;
  logic            tick;
  logic [TB_W-1:0] cnt_q;
  logic [TB_W-1:0] cnt_nxt;

  // divider is 4^psc, terminal prescale count is that minus one
  always_comb begin
    lim  = PS_W'((1 << (2 * int'(psc))) - 1);
    tick = (pc_q >= lim);
  end

  always_comb begin
    cnt_nxt = cnt_q + TB_W'(1);
    if (!wide) cnt_nxt[TB_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q <= tick ? '0 : pc_q + PS_W'(1);
      if (tick) cnt_q <= cnt_nxt;
    end
  end

  assign count = cnt_q;

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == '0);

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/icap_edge.sv
module icap_edge #(
  parameter int SYNC_N = 2,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       clr,
  input  logic [3:0] mode,
  input  logic       din,
  output logic       hit
);
  import icap_pkg::*;

  localparam int DW = $clog2(DIV_B) + 1;

  logic [SYNC_N:0] sh_q;
  logic            rise;
  logic            fall;
  logic [DW-1:0]   dcnt_q;
  logic            nth_mode;
  logic [DW-1:0]   dlast;

  // synchronizer stages plus one history flop for edge detection
  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_N; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sh_q[gi] <= 1'b0;
        else if (gi == 0) sh_q[gi] <= din;
        else sh_q[gi] <= sh_q[(gi > 0) ? gi - 1 : 0];
      end
    end
  endgenerate

  always_comb begin
    rise     = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    fall     = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
    nth_mode = (mode == MD_NTH_A) || (mode == MD_NTH_B);
    dlast    = (mode == MD_NTH_A) ? DW'(DIV_A - 1) : DW'(DIV_B - 1);
  end

  always_comb begin
    case (mode)
      MD_BOTH_A, MD_BOTH_B: hit = rise | fall;
      MD_RISE:              hit = rise;
      MD_FALL:              hit = fall;
      MD_NTH_A, MD_NTH_B:   hit = rise && (dcnt_q == dlast);
      default:              hit = 1'b0;
    endcase
    if (!en) hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !en) dcnt_q <= '0;
    else if (rise && nth_mode) dcnt_q <= (dcnt_q == dlast) ? '0 : dcnt_q + DW'(1);
  end

  a_r7_div_range: assert property (@(posedge clk) disable iff (rst)
    dcnt_q < DW'(DIV_B));

  a_r5_hit_needs_edge: assert property (@(posedge clk) disable iff (rst)
    hit |-> (rise || fall));

endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int TB_W     = 32,
  parameter int NARROW_W = 16,
  parameter int SYNC_N   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  output logic [7:0]      ctl_rdata,
  input  logic            cap_in,
  output logic [TB_W-1:0] tb_count,
  output logic [TB_W-1:0] cap_value,
  output logic            cap_flag
);
  import icap_pkg::*;

  localparam logic [TB_W-1:0] NMASK = TB_W'((64'(1) << NARROW_W) - 64'(1));

  icap_ctl_t       ctl_q;
  icap_ctl_t       ctl_w;
  logic            mode_chg;
  logic            hit;
  logic [TB_W-1:0] count;
  logic [TB_W-1:0] cap_q;
  logic            flag_q;
  logic            resv;

  always_comb begin
    ctl_w    = icap_ctl_t'(ctl_wdata);
    mode_chg = ctl_we && (ctl_w.mode != ctl_q.mode);
    resv     = ctl_q.mode[3] || (ctl_q.mode[2:1] == 2'b11);
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_w.en ? ctl_w : '0;
  end

  icap_timebase #(.TB_W(TB_W), .NARROW_W(NARROW_W), .PS_W(6)) u_tb (
    .clk(clk), .rst(rst), .en(ctl_q.en), .wide(ctl_q.wide),
    .psc(ctl_q.psc), .count(count)
  );

  icap_edge #(.SYNC_N(SYNC_N), .DIV_A(4), .DIV_B(16)) u_edge (
    .clk(clk), .rst(rst), .en(ctl_q.en), .clr(mode_chg),
    .mode(ctl_q.mode), .din(cap_in), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= hit;
      if (hit) cap_q <= count;
    end
  end

  assign ctl_rdata = ctl_q;
  assign tb_count  = ctl_q.wide ? count : (count & NMASK);
  assign cap_value = ctl_q.wide ? cap_q : (cap_q & NMASK);
  assign cap_flag  = flag_q;

  a_r2_off_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_wdata[0]) |=> ctl_q == '0);

  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    resv |=> !flag_q);

  a_r9_capture_value: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> cap_q == $past(count));

endmodule

// File: tb/icap_unit_bench.sv
module icap_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        cap_in = 1'b0;
  logic [31:0] tb_count;
  logic [31:0] cap_value;
  logic        cap_flag;

  int vec = 0;
  int bad = 0;
  int cyc = 0;
  int e_edge = 0;
  int rcnt = 0;
  bit done = 0;
  bit cur_en = 0;
  bit cur_w = 0;
  logic [1:0] cur_ps = '0;
  logic [3:0] cur_md = '0;
  logic [31:0] last_cap = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  icap_unit u_icap_unit (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cap_in(cap_in), .tb_count(tb_count),
    .cap_value(cap_value), .cap_flag(cap_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mask_of(bit w);
    return w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] tb_exp(int m);
    int d;
    d = 1 << (2 * int'(cur_ps));
    return cur_en ? (32'((m - e_edge) / d) & mask_of(cur_w)) : 32'd0;
  endfunction

  // write the control word; the write edge lies between the two negedges
  task automatic cfg(input bit en, input logic [1:0] ps, input bit w, input logic [3:0] md);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = {md, w, ps, en};
    @(negedge clk);
    ctl_we = 1'b0;
    if (!en || md != cur_md) rcnt = 0;
    if (en && !cur_en) e_edge = cyc;
    cur_en = en;
    if (en) begin
      cur_ps = ps; cur_w = w; cur_md = md;
    end else begin
      cur_ps = '0; cur_w = 0; cur_md = '0;
    end
  endtask

  // toggle the input at a negedge and check the capture three edges later
  task automatic ev;
    int c;
    bit rise;
    bit exp_hit;
    logic [31:0] val;
    c = cyc;
    cap_in = ~cap_in;
    rise = cap_in;
    exp_hit = 0;
    if (cur_en) begin
      case (cur_md)
        4'd0, 4'd3: exp_hit = 1;                              // R6
        4'd1: exp_hit = rise;                                 // R5
        4'd2: exp_hit = !rise;                                // R5
        4'd4, 4'd5: if (rise) begin                           // R7
          rcnt++;
          if (rcnt == ((cur_md == 4'd4) ? 4 : 16)) begin
            exp_hit = 1; rcnt = 0;
          end
        end
        default: exp_hit = 0;                                 // R8
      endcase
    end
    val = tb_exp(c + 2);
    repeat (3) @(negedge clk);
    chk("R9 flag", {31'd0, cap_flag}, {31'd0, exp_hit});
    if (exp_hit) last_cap = val;
    chk("R9/R8 value", cap_value, last_cap);
    chk("R3 time base", tb_count, tb_exp(cyc));
    @(negedge clk);
    chk("R9 one-cycle flag", {31'd0, cap_flag}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ctl", {24'd0, ctl_rdata}, 32'd0);
    chk("R10 tb", tb_count, 32'd0);
    chk("R10 cap", cap_value, 32'd0);
    chk("R10 flag", {31'd0, cap_flag}, 32'd0);

    // R2: disabled block ignores edges
    for (int i = 0; i < 4; i++) ev();
    chk("R2 tb idle", tb_count, 32'd0);

    // R1 readback, R2 clear on disable
    cfg(1, 2'b10, 1, 4'd5);
    chk("R1 readback", {24'd0, ctl_rdata}, 32'h5D);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'hFE;
    @(negedge clk);
    ctl_we = 1'b0;
    cur_en = 0; cur_ps = '0; cur_w = 0; cur_md = '0; rcnt = 0;
    chk("R2 fields cleared", {24'd0, ctl_rdata}, 32'd0);
    @(negedge clk);
    chk("R2 tb cleared", tb_count, 32'd0);

    // sweep of every mode over every prescale, width alternating
    for (int md = 0; md < 16; md++) begin
      for (int ps = 0; ps < 4; ps++) begin
        cfg(0, 2'b00, 0, 4'd0);
        cfg(1, 2'(ps), bit'(md[0] ^ ps[0]), 4'(md));
        for (int t = 0; t < 36; t++) ev();
      end
    end

    // R7: same-mode rewrite keeps count, changing mode clears it
    cfg(0, 2'b00, 0, 4'd0);
    cfg(1, 2'b00, 0, 4'd4);
    for (int t = 0; t < 4; t++) ev();
    cfg(1, 2'b00, 0, 4'd4);
    for (int t = 0; t < 4; t++) ev();
    for (int t = 0; t < 4; t++) ev();
    cfg(1, 2'b00, 0, 4'd6);
    cfg(1, 2'b00, 0, 4'd4);
    for (int t = 0; t < 8; t++) ev();

    // R4: 16-bit wrap
    cfg(0, 2'b00, 0, 4'd0);
    cfg(1, 2'b00, 0, 4'd1);
    repeat (65535) @(negedge clk);
    chk("R4 narrow top", tb_count, 32'h0000_FFFF);
    repeat (3) @(negedge clk);
    chk("R4 narrow wrap", tb_count, 32'd2);
    for (int t = 0; t < 2; t++) ev();

    // R4: 32-bit carries past 16 bits
    cfg(0, 2'b00, 0, 4'd0);
    cfg(1, 2'b00, 1, 4'd1);
    repeat (65538) @(negedge clk);
    chk("R4 wide carry", tb_count, 32'd65538);
    for (int t = 0; t < 2; t++) ev();
    chk("R4 wide capture", cap_value, last_cap);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule